// File: doc/BRIEF.md
# Pre-addressed DRAM read message engine

This block is the requester end of a narrow point-to-point memory link whose lines carry addresses and data in turn. It turns local requests into framed messages on a 2-bit outbound lane. It also rebuilds data bursts that arrive on a 2-bit inbound lane. A framing strobe on each direction marks where a message starts and ends. Bits travel most significant first, two per clock.

A requester can post a 48-bit block address into one of eight slots at the far end ahead of need. Later it starts the read with a 7-bit trigger that names only the slot, so the latency-critical message takes four clocks instead of twenty-eight. A full read that carries its own address is also available; it reserves a slot as its tag. The block keeps a mirror of every slot (empty, posted, or read outstanding) and the burst size chosen for it. It refuses requests that would overwrite a live slot. It frees a slot only when the last byte of its burst has arrived. Error replies from the far end are reported with their slot.

Top module: `rdmsg_engine`

## Requirements
- R1: After reset tx_frame, rsp_valid and rsp_err are low and every slot is empty, so a post (req_op 0) to any slot has req_ready high.
- R2: An accepted post (req_op 0) drives tx_frame high for exactly 28 clocks, starting the clock after acceptance, with the 56 bits {4'h1, slot[2:0], burst, addr[47:0]} on tx_lane, two bits per clock, most significant first; burst 0 means 64 bytes and 1 means 128 bytes.
- R3: An accepted trigger (req_op 1) sends 4 clocks of {4'h2, slot[2:0], 1'b0}, the trailing zero being padding.
- R4: An accepted full read (req_op 2) sends 28 clocks of {4'h3, slot[2:0], burst, addr[47:0]}.
- R5: A post or full read is accepted only for an empty slot, a trigger only for a slot with no read outstanding (so a trigger to an empty slot is sent), nothing is accepted while a message is being sent, and req_op 3 is never accepted.
- R6: An inbound frame starting with the byte {4'h4, slot, 1'b0} for a slot with a read outstanding is followed by payload bytes of 4 dibits each, most significant first; each byte appears on rsp_data with rsp_valid and rsp_slot one clock after its last dibit, and the burst size recorded for that slot (64 or 128) sets how many bytes are delivered, with rsp_last on the final one.
- R7: The slot returns to empty on the clock edge that captures the last dibit of its final byte: req_ready for a new request to that slot is low before that edge and high after it.
- R8: An inbound header {4'hF, slot, 1'b0} pulses rsp_err with rsp_slot one clock after the header, with no rsp_valid, and leaves the slot state unchanged.
- R9: Payload beyond the burst length, frames with any other opcode, and data headers naming a slot with no read outstanding produce no rsp_valid.
- R10: A slot freed by an inbound burst and a request accepted to another slot on the same clock edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | 0 post, 1 trigger, 2 full read, 3 invalid |
| req_slot | input | 3 | Slot index |
| req_long | input | 1 | Burst size: 0 = 64 bytes, 1 = 128 bytes |
| req_addr | input | 48 | Block address |
| req_ready | output | 1 | Request would be accepted this clock |
| tx_frame | output | 1 | Outbound message strobe |
| tx_lane | output | 2 | Outbound dibit |
| rx_frame | input | 1 | Inbound message strobe |
| rx_lane | input | 2 | Inbound dibit |
| rsp_valid | output | 1 | Payload byte valid |
| rsp_data | output | 8 | Payload byte |
| rsp_last | output | 1 | Final byte of a burst |
| rsp_slot | output | 3 | Slot of the byte or error |
| rsp_err | output | 1 | Error reply received |

## Verification
The slot table can be written by the outbound side, when a request is accepted, and by the inbound side, when a burst completes, on the same clock edge. The bench drives the final dibit of a 128-byte burst for one slot in the same cycle it raises a post to another slot. It then checks that the post went out on the lane and that the first slot now takes a full read while the second refuses a second post. The same-slot case is judged through req_ready, which must stay low up to the completing edge and rise right after it.

// File: rtl/rdmsg_engine.sv
module rdmsg_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [2:0]  req_slot,
  input  logic        req_long,
  input  logic [47:0] req_addr,
  output logic        req_ready,
  output logic        tx_frame,
  output logic [1:0]  tx_lane,
  input  logic        rx_frame,
  input  logic [1:0]  rx_lane,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        rsp_last,
  output logic [2:0]  rsp_slot,
  output logic        rsp_err
);
  localparam logic [1:0] EMPTY = 2'd0, POSTED = 2'd1, BUSY = 2'd2;
  localparam int MSG_W = 56;

  logic [1:0] st [8];
  logic [7:0] slen;
  logic [MSG_W-1:0] tx_sh;
  logic [4:0] tx_cnt;
  logic legal, accept;
  logic [3:0] opc;
  logic [MSG_W-1:0] msg;

  always_comb begin
    case (req_op)
      2'd0, 2'd2: legal = (st[req_slot] == EMPTY);
      2'd1:       legal = (st[req_slot] != BUSY);
      default:    legal = 1'b0;
    endcase
  end

  assign req_ready = (tx_cnt == 5'd0) && legal;
  assign accept    = req_valid && req_ready;
  assign opc       = (req_op == 2'd0) ? 4'h1 : 4'h3;
  assign msg       = (req_op == 2'd1) ? {4'h2, req_slot, 1'b0, 48'h0}
                                      : {opc, req_slot, req_long, req_addr};
  assign tx_frame  = (tx_cnt != 5'd0);
  assign tx_lane   = tx_sh[MSG_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      tx_cnt <= '0;
    end else if (accept) begin
      tx_sh  <= msg;
      tx_cnt <= (req_op == 2'd1) ? 5'd4 : 5'd28;
    end else if (tx_cnt != 5'd0) begin
      tx_sh  <= {tx_sh[MSG_W-3:0], 2'b00};
      tx_cnt <= tx_cnt - 5'd1;
    end
  end

  logic [9:0] rx_cnt;
  logic [5:0] rx_sh;
  logic [7:0] rx_byte;
  logic       byte_done, hdr_done, in_data, last_byte, free;
  logic [2:0] cur_slot;
  logic [6:0] bidx;

  assign rx_byte   = {rx_sh, rx_lane};
  assign byte_done = rx_frame && (rx_cnt[1:0] == 2'd3);
  assign hdr_done  = byte_done && (rx_cnt == 10'd3);
  assign last_byte = (bidx == {slen[cur_slot], 6'h3F});
  assign free      = byte_done && !hdr_done && in_data && last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt    <= '0;
      rx_sh     <= '0;
      in_data   <= 1'b0;
      cur_slot  <= '0;
      bidx      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_last  <= 1'b0;
      rsp_slot  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_err   <= 1'b0;
      rx_sh     <= {rx_sh[3:0], rx_lane};
      rx_cnt    <= rx_frame ? rx_cnt + 10'd1 : 10'd0;
      if (!rx_frame) in_data <= 1'b0;
      if (hdr_done) begin
        if (rx_byte[7:4] == 4'h4 && st[rx_byte[3:1]] == BUSY) begin
          in_data  <= 1'b1;
          cur_slot <= rx_byte[3:1];
          bidx     <= '0;
        end else if (rx_byte[7:4] == 4'hF) begin
          rsp_err  <= 1'b1;
          rsp_slot <= rx_byte[3:1];
        end
      end else if (byte_done && in_data) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rx_byte;
        rsp_slot  <= cur_slot;
        rsp_last  <= last_byte;
        bidx      <= bidx + 7'd1;
        if (last_byte) in_data <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) st[i] <= EMPTY;
      slen <= '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (accept && req_slot == 3'(i)) begin
          if (req_op == 2'd1) begin
            if (st[i] == POSTED) st[i] <= BUSY;
          end else begin
            st[i]   <= (req_op == 2'd0) ? POSTED : BUSY;
            slen[i] <= req_long;
          end
        end else if (free && cur_slot == 3'(i)) begin
          st[i] <= EMPTY;
        end
      end
    end
  end
endmodule

module rdmsg_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       req_ready,
  input logic       tx_frame,
  input logic [1:0] tx_lane,
  input logic       rx_frame,
  input logic       rsp_valid,
  input logic       rsp_last,
  input logic       rsp_err
);
  a_r5_busy_lane: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame |-> !req_ready);
  a_r5_no_op3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 2'd3) |-> !req_ready);
  a_r2_post_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> tx_frame && tx_lane == 2'b00 ##1 tx_lane == 2'b01);
  a_r3_trig_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd1) |=> tx_frame && tx_lane == 2'b00 ##1 tx_lane == 2'b10);
  a_r4_full_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd2) |=> tx_frame && tx_lane == 2'b00 ##1 tx_lane == 2'b11);
  a_r6_last_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);
  a_r6_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rx_frame));
  a_r8_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !rsp_valid && $past(rx_frame));
endmodule

bind rdmsg_engine rdmsg_engine_chk u_chk (.*);

// File: tb/rdmsg_engine_tb.sv
module rdmsg_engine_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_long = 0;
  logic [1:0] req_op = 0;
  logic [2:0] req_slot = 0;
  logic [47:0] req_addr = 0;
  logic req_ready, tx_frame, rx_frame = 0;
  logic [1:0] tx_lane, rx_lane = 0;
  logic rsp_valid, rsp_last, rsp_err;
  logic [7:0] rsp_data;
  logic [2:0] rsp_slot;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rdmsg_engine u_dut (.*);

  int mb = 0, mlast = 0, mbad = 0, merr = 0;
  logic [2:0] meslot = 0;
  logic [7:0] mseed = 0;
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (rsp_data !== mseed + 8'(mb)) mbad++;
      if (rsp_last) mlast++;
      mb++;
    end
    if (rsp_err) begin merr++; meslot = rsp_slot; end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mclr(input logic [7:0] seed);
    mb = 0; mlast = 0; mbad = 0; merr = 0; mseed = seed;
  endtask

  task automatic do_req(input logic [1:0] op, input logic [2:0] sl, input logic ln,
                        input logic [47:0] ad, output logic rdy, output int n,
                        output logic [55:0] cap);
    @(negedge clk);
    req_op = op; req_slot = sl; req_long = ln; req_addr = ad; req_valid = 1;
    #1 rdy = req_ready;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    cap = '0; n = 0;
    while (tx_frame && n < 40) begin
      cap = {cap[53:0], tx_lane};
      n++;
      @(negedge clk);
    end
  endtask

  task automatic send_rsp(input logic [7:0] hdr, input int nb, input logic [7:0] seed,
                          input logic go, output logic rb, output logic ra);
    logic [7:0] b;
    rb = 0;
    for (int k = 0; k <= nb; k++) begin
      b = (k == 0) ? hdr : seed + 8'(k - 1);
      for (int d = 0; d < 4; d++) begin
        @(negedge clk);
        rx_frame = 1;
        rx_lane = b[7 - 2*d -: 2];
        if (k == nb && d == 3) begin
          if (go) req_valid = 1;
          #1 rb = req_ready;
        end
      end
    end
    @(negedge clk);
    rx_frame = 0; req_valid = 0;
    #1 ra = req_ready;
  endtask

  // {op, slot, burst, addr, dibits, message (right-aligned)}
  localparam logic [114:0] VEC [9] = '{
    {2'd0, 3'd0, 1'b0, 48'h0123456789AB, 5'd28, 56'h100123456789AB},
    {2'd0, 3'd3, 1'b1, 48'hFFFF0000FFFF, 5'd28, 56'h17FFFF0000FFFF},
    {2'd0, 3'd3, 1'b0, 48'h000000000001, 5'd0,  56'h0},
    {2'd1, 3'd3, 1'b0, 48'h0,            5'd4,  56'h26},
    {2'd1, 3'd3, 1'b0, 48'h0,            5'd0,  56'h0},
    {2'd2, 3'd7, 1'b0, 48'hA5A55A5A0F0F, 5'd28, 56'h3EA5A55A5A0F0F},
    {2'd2, 3'd7, 1'b1, 48'h111111111111, 5'd0,  56'h0},
    {2'd3, 3'd1, 1'b0, 48'h222222222222, 5'd0,  56'h0},
    {2'd1, 3'd5, 1'b0, 48'h0,            5'd4,  56'h2A}
  };

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic rdy, rb, ra;
    int n;
    logic [55:0] cap;

    repeat (4) @(negedge clk);
    rst_n = 1;
    req_op = 0; req_slot = 4;
    #1;
    chk("R1 tx_frame", tx_frame, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rsp_err", rsp_err, 0);
    chk("R1 post ready", req_ready, 1);

    for (int v = 0; v < 9; v++) begin
      logic [114:0] e;
      e = VEC[v];
      do_req(e[114:113], e[112:110], e[109], e[108:61], rdy, n, cap);
      chk($sformatf("R5 vec%0d ready", v), rdy, (e[60:56] != 0));
      chk($sformatf("R2 R3 R4 vec%0d dibits", v), n, e[60:56]);
      chk($sformatf("R2 R3 R4 vec%0d message", v), cap, e[55:0]);
    end

    // R7: slot 7 (64-byte burst) frees exactly at its final byte
    req_op = 2; req_slot = 7; req_valid = 0;
    mclr(8'h40);
    send_rsp(8'h4E, 64, 8'h40, 0, rb, ra);
    chk("R7 ready before final edge", rb, 0);
    chk("R7 ready after final edge", ra, 1);
    @(negedge clk);
    chk("R6 64-byte count", mb, 64);
    chk("R6 64-byte last", mlast, 1);
    chk("R6 64-byte data", mbad, 0);

    // R10: slot 3 completes while a post to slot 6 is accepted
    req_op = 0; req_slot = 6; req_long = 0; req_addr = 48'h1;
    mclr(8'h80);
    send_rsp(8'h46, 128, 8'h80, 1, rb, ra);
    chk("R10 post launched", tx_frame, 1);
    @(negedge clk);
    chk("R6 128-byte count", mb, 128);
    chk("R6 128-byte last", mlast, 1);
    chk("R6 128-byte data", mbad, 0);
    repeat (30) @(negedge clk);
    req_op = 2; req_slot = 3; #1;
    chk("R10 slot3 freed", req_ready, 1);
    req_op = 0; req_slot = 6; #1;
    chk("R10 slot6 posted", req_ready, 0);
    req_op = 1; #1;
    chk("R10 slot6 triggerable", req_ready, 1);

    // R9: extra payload ignored
    do_req(2'd1, 3'd0, 1'b0, 48'h0, rdy, n, cap);
    chk("R3 trigger slot0", cap, 56'h20);
    mclr(8'h10);
    send_rsp(8'h40, 67, 8'h10, 0, rb, ra);
    @(negedge clk);
    chk("R9 extra bytes dropped", mb, 64);
    chk("R9 single last", mlast, 1);

    mclr(8'h00);
    send_rsp(8'h70, 4, 8'h00, 0, rb, ra);
    @(negedge clk);
    chk("R9 unknown opcode", mb + merr, 0);
    send_rsp(8'h40, 4, 8'h00, 0, rb, ra);
    @(negedge clk);
    chk("R9 data for idle slot", mb, 0);

    // R8: error reply for empty slot 5
    mclr(8'h00);
    send_rsp(8'hFA, 0, 8'h00, 0, rb, ra);
    @(negedge clk);
    chk("R8 error count", merr, 1);
    chk("R8 error slot", meslot, 5);
    chk("R8 no data", mb, 0);
    req_op = 0; req_slot = 5; #1;
    chk("R8 slot5 still empty (post)", req_ready, 1);
    req_op = 1; #1;
    chk("R8 slot5 trigger ready", req_ready, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule